// File: doc/BRIEF.md
# Programmable-Timing SPI Master

This block is the transfer engine of an SPI master. Each transfer moves one frame of 1 to 16 bits. Every interval on the wire comes from its own software count:
- how long SCK stays high;
- how long SCK stays low;
- the lead time from chip-select assertion to the first clock edge;
- the hold time from the last clock edge to chip-select release;
- the minimum time chip-select stays deasserted before another frame.

A count of N gives N+1 system-clock cycles, so a count of zero still gives a one-cycle phase.

Software supplies the configuration and a start strobe that carries the transmit word. The engine then drives SCK, MOSI and an active-low chip-select, and it samples MISO. After the last edge it presents the received word together with a one-cycle receive pulse. A one-cycle transmit-empty pulse marks the cycle in which the transmit word was taken.

Two transfer modes change what data moves. In transmit-only mode the received data is discarded. In receive-only mode a frame is launched by a trigger strobe instead of the start strobe, and MOSI stays low.

Continuous chip-select mode keeps the select asserted between frames until software issues a release command. Clearing the enable input abandons any transfer at once.

Top module: `spi_timed_master`

## Requirements
- R1: While the engine is idle, and in every cycle outside the clocking phases, SCK sits at the `cpol` level (0 = rests low, 1 = rests high).
- R2: The first SCK edge comes `cs_setup_cnt`+1 cycles after chip-select asserts. SCK then alternates between two levels. At the level opposite `cpol` it stays for (`cpol`=0 ? `sck_hi_cnt` : `sck_lo_cnt`)+1 cycles. At the `cpol` level between bits it stays for the other count +1 cycles.
- R3: Chip-select deasserts `cs_hold_cnt`+1 cycles after the last SCK edge. The engine returns to idle `cs_idle_cnt`+1 cycles after chip-select deasserts.
- R4: With `cpha`=1, data is captured on the first edge of each bit (the edge away from the rest level). With `cpha`=0, data is captured on the second edge. MOSI holds the outgoing bit at every capture edge. With `tx_msb_first`=1 the first bit sent is `tx_data[N-1]`; with 0 it is `tx_data[0]`.
- R5: MISO is sampled at each capture edge. With `rx_msb_first`=1 the first received bit lands in `rx_data[N-1]`, and with 0 it lands in `rx_data[0]`. The bits of `rx_data` from N upward are zero.
- R6: A frame holds N = `frame_len`+1 bits, so it has exactly 2N SCK edges.
- R7: With `cont_cs`=1, chip-select stays asserted after the hold interval until `cs_release` is seen. It deasserts in the cycle after the release. `cs_release` has no effect while `cont_cs`=0.
- R8: With `tx_only`=1, no `rx_full` pulse is produced and `rx_data` keeps its previous value.
- R9: With `rx_only`=1, a frame starts on `rx_trig`, `start` is ignored, MOSI stays 0 and no `tx_empty` pulse is produced.
- R10: `busy` is high from the cycle after a frame is accepted until chip-select deasserts (or the link state is entered). `idle` is high only when the engine is fully quiescent, and never together with `busy`.
- R11: A start strobe arriving while a frame is in progress is ignored. The frame in progress and its data are unaffected, and no further frame follows.
- R12: Clearing `en` returns SCK to the `cpol` level, deasserts chip-select and drops `busy` at the next clock edge.
- R13: `tx_empty` pulses for one cycle in the first cycle after a frame is accepted. `rx_full` pulses for one cycle together with the new `rx_data`, in the cycle after the last SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable; low aborts and holds idle |
| sck_hi_cnt | input | 8 | SCK high phase length minus one |
| sck_lo_cnt | input | 8 | SCK low phase length minus one |
| cs_setup_cnt | input | 8 | Select-to-first-edge delay minus one |
| cs_hold_cnt | input | 8 | Last-edge-to-deselect delay minus one |
| cs_idle_cnt | input | 8 | Minimum deselected time minus one |
| cpol | input | 1 | SCK rest level |
| cpha | input | 1 | 1: capture on first edge, 0: on second edge |
| tx_msb_first | input | 1 | Transmit bit order |
| rx_msb_first | input | 1 | Receive bit order |
| frame_len | input | 4 | Bits per frame minus one |
| cont_cs | input | 1 | Hold chip-select between frames |
| tx_only | input | 1 | Discard received data |
| rx_only | input | 1 | Trigger-started receive, MOSI low |
| start | input | 1 | Start strobe, takes tx_data |
| tx_data | input | 16 | Word to transmit |
| rx_trig | input | 1 | Receive-only start strobe |
| cs_release | input | 1 | Release held chip-select |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low chip-select |
| rx_data | output | 16 | Last received word |
| busy | output | 1 | Frame in progress |
| idle | output | 1 | Engine fully quiescent |
| tx_empty | output | 1 | One-cycle transmit-word-taken pulse |
| rx_full | output | 1 | One-cycle receive-word-ready pulse |

## Verification
A wrong phase counter or state shows on the wire almost at once. Every later SCK edge, and the chip-select release, moves by whole cycles, and the first misplaced edge reveals this within one SCK phase of the fault. A wrong bit position or bit-order decision does not alter the timing. It appears as a wrong MOSI level at the next capture edge, or as a wrong bit in the word returned with the receive pulse at the end of that frame. State-machine faults around continuous select, abort and ignored strobes show up within a cycle or two as a chip-select, busy or idle level that differs from the expected one.

// File: rtl/spi_tm_pkg.sv
package spi_tm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_ACT   = 3'd2,
    ST_REST  = 3'd3,
    ST_HOLD  = 3'd4,
    ST_LINK  = 3'd5,
    ST_GAP   = 3'd6
  } spi_tm_state_e;

endpackage

// File: rtl/spi_tm_phase_timer.sv
module spi_tm_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Load on a phase change, otherwise count down to zero and stay there.
  always_comb begin
    cnt_en = load | (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/spi_tm_ctrl.sv
module spi_tm_ctrl
  import spi_tm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] sck_hi_cnt,
  input  logic [CNT_W-1:0] sck_lo_cnt,
  input  logic [CNT_W-1:0] cs_setup_cnt,
  input  logic [CNT_W-1:0] cs_hold_cnt,
  input  logic [CNT_W-1:0] cs_idle_cnt,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             cont_cs,
  input  logic             rx_only,
  input  logic             start,
  input  logic             rx_trig,
  input  logic             cs_release,
  input  logic             tmr_done,
  output spi_tm_state_e    st,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             tx_adv,
  output logic             rx_cap,
  output logic             frame_end
);

  spi_tm_state_e    st_q, st_d;
  logic [LEN_W-1:0] bcnt_q, bcnt_d;
  logic             bcnt_en;
  logic             last_bit;
  logic             lead, trail;
  logic             go_req;
  logic [CNT_W-1:0] act_len, rest_len;

  // Active level is the opposite of the rest level; pick counts by level.
  assign act_len  = cpol ? sck_lo_cnt : sck_hi_cnt;
  assign rest_len = cpol ? sck_hi_cnt : sck_lo_cnt;
  assign last_bit = (bcnt_q == frame_len);
  assign go_req   = rx_only ? rx_trig : start;

  always_comb begin
    accept = en & go_req &
             ((st_q == ST_IDLE) | ((st_q == ST_LINK) & ~cs_release));
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept)   st_d = ST_SETUP;
      ST_SETUP: if (tmr_done) st_d = ST_ACT;
      ST_ACT:   if (tmr_done) st_d = last_bit ? ST_HOLD : ST_REST;
      ST_REST:  if (tmr_done) st_d = ST_ACT;
      ST_HOLD:  if (tmr_done) st_d = cont_cs ? ST_LINK : ST_GAP;
      ST_LINK: begin
        if (cs_release)  st_d = ST_GAP;
        else if (accept) st_d = ST_SETUP;
      end
      ST_GAP:   if (tmr_done) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    if (!en) st_d = ST_IDLE;
  end

  always_comb begin
    tmr_load = (st_d != st_q);
    unique case (st_d)
      ST_SETUP: tmr_val = cs_setup_cnt;
      ST_ACT:   tmr_val = act_len;
      ST_REST:  tmr_val = rest_len;
      ST_HOLD:  tmr_val = cs_hold_cnt;
      ST_GAP:   tmr_val = cs_idle_cnt;
      default:  tmr_val = '0;
    endcase
  end

  // SCK edges are the entries into and exits from the active level.
  assign lead  = en & (st_q != ST_ACT) & (st_d == ST_ACT);
  assign trail = en & (st_q == ST_ACT) & (st_d != ST_ACT);

  assign tx_adv    = cpha ? (trail & ~last_bit) : (lead & (bcnt_q != '0));
  assign rx_cap    = cpha ? lead : trail;
  assign frame_end = trail & last_bit;

  always_comb begin
    bcnt_en = accept | trail;
    if (accept) bcnt_d = '0;
    else        bcnt_d = bcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bcnt_q <= '0;
    else if (bcnt_en) bcnt_q <= bcnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st = st_q;

endmodule

// File: rtl/spi_tm_shifter.sv
module spi_tm_shifter #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              rx_only,
  input  logic              tx_only,
  input  logic              tx_msb_first,
  input  logic              rx_msb_first,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              tx_adv,
  input  logic              rx_cap,
  input  logic              frame_end,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_empty,
  output logic              rx_full
);

  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rsh_q, rsh_d;
  logic [DATA_W-1:0] rxo_q;
  logic [LEN_W-1:0]  tpos_q, tpos_d;
  logic [LEN_W-1:0]  rpos_q, rpos_d;
  logic [LEN_W-1:0]  tx_idx, rx_idx;
  logic              tpos_en, rpos_en, rsh_en, rxo_en;
  logic              txe_q, rxf_q;

  // Bit positions are addressed directly instead of shifting the word.
  assign tx_idx = tx_msb_first ? (frame_len - tpos_q) : tpos_q;
  assign rx_idx = rx_msb_first ? (frame_len - rpos_q) : rpos_q;
  assign mosi   = ~rx_only & tx_q[tx_idx];

  always_comb begin
    tpos_en = load | tx_adv;
    tpos_d  = load ? '0 : tpos_q + 1'b1;
    rpos_en = load | rx_cap;
    rpos_d  = load ? '0 : rpos_q + 1'b1;
    rsh_en  = load | rx_cap;
    rsh_d   = rsh_q;
    if (load)        rsh_d = '0;
    else if (rx_cap) rsh_d[rx_idx] = miso;
    rxo_en  = frame_end & ~tx_only;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tx_q <= '0;
    else if (load) tx_q <= rx_only ? '0 : tx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpos_q <= '0;
      rpos_q <= '0;
    end else begin
      if (tpos_en) tpos_q <= tpos_d;
      if (rpos_en) rpos_q <= rpos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsh_q <= '0;
    else if (rsh_en) rsh_q <= rsh_d;
  end

  // The final capture (second-edge mode) lands in the same cycle as the
  // frame end, so the output copy takes the next-state word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rxo_q <= '0;
    else if (rxo_en) rxo_q <= rsh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_q <= 1'b0;
      rxf_q <= 1'b0;
    end else begin
      txe_q <= load & ~rx_only;
      rxf_q <= rxo_en;
    end
  end

  assign rx_data  = rxo_q;
  assign tx_empty = txe_q;
  assign rx_full  = rxf_q;

endmodule

// File: rtl/spi_timed_master.sv
module spi_timed_master
  import spi_tm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CNT_W-1:0]  sck_hi_cnt,
  input  logic [CNT_W-1:0]  sck_lo_cnt,
  input  logic [CNT_W-1:0]  cs_setup_cnt,
  input  logic [CNT_W-1:0]  cs_hold_cnt,
  input  logic [CNT_W-1:0]  cs_idle_cnt,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              tx_msb_first,
  input  logic              rx_msb_first,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              cont_cs,
  input  logic              tx_only,
  input  logic              rx_only,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_trig,
  input  logic              cs_release,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              idle,
  output logic              tx_empty,
  output logic              rx_full
);

  logic [1:0]       rst_pipe_q;
  logic             core_rst_n;
  spi_tm_state_e    st;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             accept, tx_adv, rx_cap, frame_end;

  // Reset asserts asynchronously and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  spi_tm_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  spi_tm_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .en           (en),
    .sck_hi_cnt   (sck_hi_cnt),
    .sck_lo_cnt   (sck_lo_cnt),
    .cs_setup_cnt (cs_setup_cnt),
    .cs_hold_cnt  (cs_hold_cnt),
    .cs_idle_cnt  (cs_idle_cnt),
    .cpol         (cpol),
    .cpha         (cpha),
    .frame_len    (frame_len),
    .cont_cs      (cont_cs),
    .rx_only      (rx_only),
    .start        (start),
    .rx_trig      (rx_trig),
    .cs_release   (cs_release),
    .tmr_done     (tmr_done),
    .st           (st),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .accept       (accept),
    .tx_adv       (tx_adv),
    .rx_cap       (rx_cap),
    .frame_end    (frame_end)
  );

  spi_tm_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .load         (accept),
    .tx_word      (tx_data),
    .rx_only      (rx_only),
    .tx_only      (tx_only),
    .tx_msb_first (tx_msb_first),
    .rx_msb_first (rx_msb_first),
    .frame_len    (frame_len),
    .tx_adv       (tx_adv),
    .rx_cap       (rx_cap),
    .frame_end    (frame_end),
    .miso         (miso),
    .mosi         (mosi),
    .rx_data      (rx_data),
    .tx_empty     (tx_empty),
    .rx_full      (rx_full)
  );

  assign sck  = (st == ST_ACT) ? ~cpol : cpol;
  assign cs_n = (st == ST_IDLE) | (st == ST_GAP);
  assign busy = (st == ST_SETUP) | (st == ST_ACT) | (st == ST_REST) |
                (st == ST_HOLD);
  assign idle = (st == ST_IDLE);

endmodule

// File: rtl/spi_timed_master_chk.sv
module spi_timed_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              cpol,
  input logic              tx_only,
  input logic              rx_only,
  input logic              sck,
  input logic              cs_n,
  input logic              busy,
  input logic              idle,
  input logic              tx_empty,
  input logic              rx_full,
  input logic [DATA_W-1:0] rx_data
);

  assert_idle_sck_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (sck == cpol));

  assert_sck_needs_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != cpol) |-> !cs_n);

  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_full);

  assert_txonly_no_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !$past(tx_only));

  assert_rxonly_no_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> !$past(rx_only));

  assert_busy_selects_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);

  assert_busy_idle_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && idle));

  assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cs_n && !busy));

  assert_empty_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |=> !tx_empty);

  assert_full_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |=> !rx_full);

endmodule

bind spi_timed_master spi_timed_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .cpol     (cpol),
  .tx_only  (tx_only),
  .rx_only  (rx_only),
  .sck      (sck),
  .cs_n     (cs_n),
  .busy     (busy),
  .idle     (idle),
  .tx_empty (tx_empty),
  .rx_full  (rx_full),
  .rx_data  (rx_data)
);

// File: tb/spi_timed_master_tb.sv
`timescale 1ns/1ps
module spi_timed_master_tb;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [7:0]  hi, lo, su, ho, gi;
  logic        cpol, cpha, txm, rxm;
  logic [3:0]  flen;
  logic        cont, txo, rxo;
  logic        start, trig, rel, miso;
  logic [15:0] txd;
  logic        sck, mosi, cs_n, busy, idle, tx_empty, rx_full;
  logic [15:0] rx_data;

  int          n_chk;
  int          n_fail;
  logic [15:0] last_rx;
  bit          finished;

  spi_timed_master u_dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .sck_hi_cnt(hi), .sck_lo_cnt(lo), .cs_setup_cnt(su),
    .cs_hold_cnt(ho), .cs_idle_cnt(gi),
    .cpol(cpol), .cpha(cpha), .tx_msb_first(txm), .rx_msb_first(rxm),
    .frame_len(flen), .cont_cs(cont), .tx_only(txo), .rx_only(rxo),
    .start(start), .tx_data(txd), .rx_trig(trig), .cs_release(rel),
    .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n), .rx_data(rx_data),
    .busy(busy), .idle(idle), .tx_empty(tx_empty), .rx_full(rx_full)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One frame, observed at every falling edge; k counts cycles after accept.
  task automatic run_frame(input bit use_trig, input logic [15:0] txw,
                           input logic [15:0] seq, input bit keep_cs, input bit poke);
    int n, a, r, per, last_tr, rise, endk, ne, ek, capk;
    int edge_bad, mosi_bad, cs_bad, busy_bad, idle_bad, rxf_n, rxf_k, txe_extra;
    logic prev, txe0;
    logic [15:0] exp_rx, exp_m, rxv;
    n = int'(flen) + 1;
    a = cpol ? int'(lo) : int'(hi);
    r = cpol ? int'(hi) : int'(lo);
    per = a + r + 2;
    last_tr = int'(su) + 1 + (n - 1) * per + a + 1;
    rise = last_tr + int'(ho) + 1;
    endk = keep_cs ? rise + 1 : rise + int'(gi) + 1;
    exp_rx = '0;
    exp_m = '0;
    for (int j = 0; j < n; j++) begin
      if (seq[j]) exp_rx[rxm ? n - 1 - j : j] = 1'b1;
      exp_m[j] = rxo ? 1'b0 : txw[txm ? n - 1 - j : j];
    end
    ne = 0; capk = 0; edge_bad = 0; mosi_bad = 0; cs_bad = 0; busy_bad = 0;
    idle_bad = 0; rxf_n = 0; rxf_k = -1; txe_extra = 0; txe0 = 1'b0;
    rxv = '0; prev = cpol;
    @(negedge clk);
    miso = seq[0];
    txd = txw;
    if (use_trig) trig = 1'b1; else start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    trig = 1'b0;
    for (int k = 0; k <= endk; k++) begin
      if (poke && k == 2) begin start = 1'b1; txd = ~txw; rel = 1'b1; end
      if (poke && k == 3) begin start = 1'b0; rel = 1'b0; end
      if (sck !== prev) begin
        ek = int'(su) + 1 + (ne / 2) * per + ((ne % 2) ? a + 1 : 0);
        if (k != ek) edge_bad++;
        if (cpha ? (sck != cpol) : (sck == cpol)) begin
          if (capk < 16 && mosi !== exp_m[capk]) mosi_bad++;
          capk++;
          if (capk < 16) miso = seq[capk];
        end
        ne++;
        prev = sck;
      end
      if (cs_n !== ((k < rise || keep_cs) ? 1'b0 : 1'b1)) cs_bad++;
      if (busy !== ((k < rise) ? 1'b1 : 1'b0)) busy_bad++;
      if (idle !== ((!keep_cs && k == endk) ? 1'b1 : 1'b0)) idle_bad++;
      if (rx_full === 1'b1) begin rxf_n++; rxf_k = k; rxv = rx_data; end
      if (k == 0) txe0 = tx_empty;
      else if (tx_empty === 1'b1) txe_extra++;
      if (k < endk) @(negedge clk);
    end
    chk("R6", "sck edge count", ne, 2 * n);
    chk("R2", "misplaced sck edges", edge_bad, 0);
    chk("R3", "cs_n level mismatches", cs_bad, 0);
    chk("R4", "mosi wrong at capture", mosi_bad, 0);
    chk("R10", "busy mismatches", busy_bad, 0);
    chk("R10", "idle mismatches", idle_bad, 0);
    chk("R13", "tx_empty at first cycle", int'(txe0), rxo ? 0 : 1);
    chk("R13", "extra tx_empty pulses", txe_extra, 0);
    if (txo) begin
      chk("R8", "rx_full pulses in tx-only", rxf_n, 0);
      chk("R8", "rx_data kept in tx-only", int'(rx_data), int'(last_rx));
    end else begin
      chk("R13", "rx_full pulse count", rxf_n, 1);
      chk("R13", "rx_full cycle", rxf_k, last_tr);
      chk("R5", "received word", int'(rxv), int'(exp_rx));
      last_rx = exp_rx;
    end
    if (poke) begin
      chk("R7", "release without cont ignored", cs_bad, 0);
      cs_bad = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (cs_n !== 1'b1 || idle !== 1'b1) cs_bad++;
      end
      chk("R11", "start during frame started nothing", cs_bad, 0);
    end
  endtask

  task automatic release_link();
    int bad;
    bad = 0;
    @(negedge clk);
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
    chk("R7", "cs_n after release", int'(cs_n), 1);
    for (int k = 0; k <= int'(gi) + 1; k++) begin
      if (k > 0) @(negedge clk);
      if (idle !== ((k == int'(gi) + 1) ? 1'b1 : 1'b0) || cs_n !== 1'b1) bad++;
    end
    chk("R3", "gap after release", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; last_rx = '0; finished = 1'b0;
    rst_n = 1'b0; en = 1'b1;
    hi = 0; lo = 0; su = 0; ho = 0; gi = 0;
    cpol = 0; cpha = 0; txm = 0; rxm = 0; flen = 0;
    cont = 0; txo = 0; rxo = 0;
    start = 0; trig = 0; rel = 0; miso = 0; txd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "sck after reset", int'(sck), 0);
    chk("R3", "cs_n after reset", int'(cs_n), 1);
    chk("R10", "idle after reset", int'(idle), 1);
    chk("R10", "busy after reset", int'(busy), 0);
    chk("R5", "rx_data after reset", int'(rx_data), 0);

    // Mode sweep: polarity, phase and both bit orders with varied timing.
    for (int m = 0; m < 16; m++) begin
      cpol = m[0]; cpha = m[1]; txm = m[2]; rxm = m[3];
      flen = 4'((m * 5 + 3) % 16);
      hi = 8'(m % 3); lo = 8'((m + 1) % 3); su = 8'(m % 4);
      ho = 8'((m / 2) % 3); gi = 8'(m % 2);
      @(negedge clk);
      chk("R1", "sck rest level", int'(sck), int'(cpol));
      run_frame(1'b0, 16'(16'h1234 * (m + 1)) ^ 16'hA55A, 16'h5AC3 ^ 16'(m << 4), 1'b0, 1'b0);
    end

    // Frame length sweep with zero-length phases.
    cpol = 1; cpha = 0; txm = 0; rxm = 1;
    hi = 1; lo = 0; su = 0; ho = 0; gi = 0;
    for (int l = 0; l < 16; l++) begin
      flen = 4'(l);
      run_frame(1'b0, 16'hC3A5 ^ 16'(l * 16'h0F1), 16'h9E37 ^ 16'(l * 16'h111), 1'b0, 1'b0);
    end

    // Start and release during a frame without continuous select.
    cpol = 0; cpha = 1; txm = 1; rxm = 0; flen = 9;
    hi = 2; lo = 1; su = 3; ho = 2; gi = 2;
    run_frame(1'b0, 16'h3C96, 16'h6B1D, 1'b0, 1'b1);

    // Transmit-only keeps the previous received word.
    txo = 1;
    run_frame(1'b0, 16'hF00D, 16'hFFFF, 1'b0, 1'b0);
    txo = 0;

    // Receive-only: start ignored, trigger launches.
    rxo = 1; flen = 11; cpha = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 4; k++) begin
        if (cs_n !== 1'b1 || idle !== 1'b1) bad++;
        @(negedge clk);
      end
      chk("R9", "start ignored in rx-only", bad, 0);
    end
    run_frame(1'b1, 16'hFFFF, 16'hA7E2, 1'b0, 1'b0);
    rxo = 0;

    // Continuous select across two frames, then release.
    cont = 1; cpol = 1; cpha = 1; flen = 5; su = 1; ho = 1; gi = 3;
    run_frame(1'b0, 16'h002D, 16'h0016, 1'b1, 1'b0);
    run_frame(1'b0, 16'h0031, 16'h0029, 1'b1, 1'b0);
    release_link();
    cont = 0;

    // Abort by clearing enable in the middle of a bit.
    cpol = 1; cpha = 0; flen = 7; hi = 3; lo = 3; su = 2;
    @(negedge clk);
    txd = 16'h00FF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R12", "sck active before abort", int'(sck), 0);
    en = 1'b0;
    @(negedge clk);
    chk("R12", "sck at rest after abort", int'(sck), 1);
    chk("R12", "cs_n after abort", int'(cs_n), 1);
    chk("R12", "busy after abort", int'(busy), 0);
    en = 1'b1;
    @(negedge clk);
    chk("R10", "idle after abort", int'(idle), 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule